// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block watches a bank of 32 general-purpose input pins and turns selected pin activity into interrupts. Every pin is resynchronised to the block clock and then compared against its own trigger condition. The condition can be a rising edge, a falling edge, either edge, a high level or a low level. When the condition occurs, the pin's bit in a sticky status word is set. Software clears a status bit by writing a 1 to its position.

A per-pin enable word masks which status bits drive the single combined interrupt line. Software reaches the block through a word-addressed register port with a 5-bit byte address. The port has separate write and read strobes and 32-bit data, and read data is returned one clock after the read strobe. A debounce word is also provided as plain read/write storage for software.

Register layout (byte offsets):

| Offset | Contents |
|--------|----------|
| 0x00–0x0C | Trigger fields, 4 bits per pin, 8 pins per word |
| 0x10 | Enable word, one bit per pin |
| 0x14 | Sticky status word, one bit per pin |
| 0x18 | Debounce word |
| 0x1C | Unmapped |

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is low. With all fields at 0, every pin starts in rising-edge mode with its interrupt masked.
- R2: Pin n's 4-bit trigger field lies in the configuration word at byte offset 4*(n/8), at bits (n%8)*4 and up. The configuration, enable (0x10) and debounce (0x18) words read back the last value written.
- R3: Code 0 (rising edge) sets pin n's status bit when the pin goes from 0 to 1. A 1-to-0 transition does not set it.
- R4: Code 1 (falling edge) sets the status bit when the pin goes from 1 to 0. A 0-to-1 transition does not set it.
- R5: Code 2 (high level) sets the status bit while the pin is 1. If the pin is still 1 when the bit is cleared, a read in the cycle right after the clear returns 0, and the bit is set again on the following clock.
- R6: Code 3 (low level) sets the status bit while the pin is 0.
- R7: Code 4 (both edges) sets the status bit on any change of the pin.
- R8: Codes 5 to 15 never set the pin's status bit, whatever the pin does.
- R9: A status bit is set whatever the enable word holds. `irq_o` equals the OR over all pins of (status bit AND enable bit).
- R10: Writing 1 to a status bit position clears that bit. Writing 0 to a status bit position leaves it unchanged.
- R11: A pin change applied before clock edge k first appears in status, and in `irq_o`, after edge k+2. This latency comes from the two-flop synchroniser.
- R12: Offset 0x1C reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 32 | Asynchronous pin levels |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 5 | Byte address, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after `rd_en_i` |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bound checker checks several rules on every cycle for every pin:

- a status bit survives any cycle in which it is not written with 1;
- a writing of 0 never clears a status bit;
- a synchronised rising edge in rising-edge mode sets the bit;
- a synchronised high level in high-level mode sets the bit;
- a field holding an undefined code never sets a clear bit;
- the interrupt stays low while the enable word is 0.

Only the directed scenarios can show the rest. These are the mapping of each pin to its field position, the falling, low-level and both-edge modes seen from the pins, the exact two-stage latency, and the brief drop of a level-triggered bit right after software clears it.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

    // Trigger field encodings; any other value disables the pin.
    typedef enum logic [3:0] {
        TRIG_RISE = 4'd0,
        TRIG_FALL = 4'd1,
        TRIG_HIGH = 4'd2,
        TRIG_LOW  = 4'd3,
        TRIG_BOTH = 4'd4
    } trig_e;

    localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/gpio_irq_sync.sv
`timescale 1ns/1ps
module gpio_irq_sync #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);

    // meta: first flop, sync: second flop, last: previous synchronised sample
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] sync;
        logic [W-1:0] last;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pin_i;
        st_d.sync = st_q.meta;
        st_d.last = st_q.sync;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_o  = st_q.sync;
    assign prev_o = st_q.last;

endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int FIELD_W  = 4
) (
    input  logic [NUM_PINS*FIELD_W-1:0] cfg_i,
    input  logic [NUM_PINS-1:0]         cur_i,
    input  logic [NUM_PINS-1:0]         prev_i,
    output logic [NUM_PINS-1:0]         evt_o
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic [FIELD_W-1:0] field;
        logic               rise;
        logic               fall;

        assign field = cfg_i[p*FIELD_W +: FIELD_W];
        assign rise  = cur_i[p] & ~prev_i[p];
        assign fall  = ~cur_i[p] & prev_i[p];

        always_comb begin
            case (field)
                TRIG_RISE: evt_o[p] = rise;
                TRIG_FALL: evt_o[p] = fall;
                TRIG_HIGH: evt_o[p] = cur_i[p];
                TRIG_LOW:  evt_o[p] = ~cur_i[p];
                TRIG_BOTH: evt_o[p] = rise | fall;
                default:   evt_o[p] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_irq_regs.sv
`timescale 1ns/1ps
module gpio_irq_regs #(
    parameter int NUM_PINS = 32,
    parameter int FIELD_W  = 4,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 5
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        wr_en_i,
    input  logic                        rd_en_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [DATA_W-1:0]           wdata_i,
    input  logic [NUM_PINS-1:0]         evt_i,
    output logic [NUM_PINS*FIELD_W-1:0] cfg_o,
    output logic [NUM_PINS-1:0]         en_o,
    output logic [NUM_PINS-1:0]         stat_o,
    output logic [DATA_W-1:0]           rdata_o
);

    localparam int WIDX_W    = ADDR_W - 2;
    localparam int CFG_WORDS = (NUM_PINS * FIELD_W) / DATA_W;
    localparam int EN_IDX    = CFG_WORDS;
    localparam int STAT_IDX  = CFG_WORDS + 1;
    localparam int DEB_IDX   = CFG_WORDS + 2;

    typedef struct packed {
        logic [NUM_PINS*FIELD_W-1:0] cfg;
        logic [NUM_PINS-1:0]         en;
        logic [NUM_PINS-1:0]         stat;
        logic [DATA_W-1:0]           deb;
        logic [DATA_W-1:0]           rdata;
    } reg_st_t;

    reg_st_t             st_d, st_q;
    logic [WIDX_W-1:0]   widx;
    logic [NUM_PINS-1:0] clr;

    assign widx = addr_i[ADDR_W-1:2];

    always_comb begin
        st_d = st_q;
        clr  = '0;

        if (wr_en_i) begin
            if (int'(widx) < CFG_WORDS) begin
                st_d.cfg[int'(widx)*DATA_W +: DATA_W] = wdata_i;
            end else if (int'(widx) == EN_IDX) begin
                st_d.en = wdata_i[NUM_PINS-1:0];
            end else if (int'(widx) == STAT_IDX) begin
                clr = wdata_i[NUM_PINS-1:0];
            end else if (int'(widx) == DEB_IDX) begin
                st_d.deb = wdata_i;
            end
        end

        // A clear in the same cycle overrides a new event.
        st_d.stat = (st_q.stat | evt_i) & ~clr;

        if (rd_en_i) begin
            st_d.rdata = '0;
            if (int'(widx) < CFG_WORDS) begin
                st_d.rdata = st_q.cfg[int'(widx)*DATA_W +: DATA_W];
            end else if (int'(widx) == EN_IDX) begin
                st_d.rdata[NUM_PINS-1:0] = st_q.en;
            end else if (int'(widx) == STAT_IDX) begin
                st_d.rdata[NUM_PINS-1:0] = st_q.stat;
            end else if (int'(widx) == DEB_IDX) begin
                st_d.rdata = st_q.deb;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o   = st_q.cfg;
    assign en_o    = st_q.en;
    assign stat_o  = st_q.stat;
    assign rdata_o = st_q.rdata;

endmodule

// File: rtl/gpio_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_irq_ctrl #(
    parameter int NUM_PINS = 32,
    parameter int FIELD_W  = 4,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 5
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                wr_en_i,
    input  logic                rd_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic                irq_o
);

    logic [NUM_PINS-1:0]         cur_w;
    logic [NUM_PINS-1:0]         prev_w;
    logic [NUM_PINS-1:0]         evt_w;
    logic [NUM_PINS*FIELD_W-1:0] cfg_w;
    logic [NUM_PINS-1:0]         en_w;
    logic [NUM_PINS-1:0]         stat_w;

    gpio_irq_sync #(
        .W (NUM_PINS)
    ) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (pin_i),
        .cur_o  (cur_w),
        .prev_o (prev_w)
    );

    gpio_irq_detect #(
        .NUM_PINS (NUM_PINS),
        .FIELD_W  (FIELD_W)
    ) i_detect (
        .cfg_i  (cfg_w),
        .cur_i  (cur_w),
        .prev_i (prev_w),
        .evt_o  (evt_w)
    );

    gpio_irq_regs #(
        .NUM_PINS (NUM_PINS),
        .FIELD_W  (FIELD_W),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) i_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .evt_i   (evt_w),
        .cfg_o   (cfg_w),
        .en_o    (en_w),
        .stat_o  (stat_w),
        .rdata_o (rdata_o)
    );

    assign irq_o = |(stat_w & en_w);

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_chk #(
    parameter int NUM_PINS = 32,
    parameter int FIELD_W  = 4,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 5
) (
    input logic                        clk_i,
    input logic                        rst_ni,
    input logic                        wr_en_i,
    input logic [ADDR_W-1:0]           addr_i,
    input logic [DATA_W-1:0]           wdata_i,
    input logic                        irq_i,
    input logic [NUM_PINS*FIELD_W-1:0] cfg_i,
    input logic [NUM_PINS-1:0]         en_i,
    input logic [NUM_PINS-1:0]         stat_i,
    input logic [NUM_PINS-1:0]         cur_i,
    input logic [NUM_PINS-1:0]         prev_i
);

    localparam int STAT_IDX = (NUM_PINS * FIELD_W) / DATA_W + 1;

    logic                stat_wr;
    logic [NUM_PINS-1:0] clr_mask;

    assign stat_wr  = wr_en_i && (int'(addr_i[ADDR_W-1:2]) == STAT_IDX);
    assign clr_mask = stat_wr ? wdata_i[NUM_PINS-1:0] : '0;

    // R9: no enabled bit means no interrupt
    a_r9_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i == '0) |-> !irq_i);

    // R10: writing zeros to status never clears anything
    a_r10_zero_write_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_wr && wdata_i == '0) |=> ((($past(stat_i)) & ~stat_i) == '0));

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
        logic [FIELD_W-1:0] fld;
        assign fld = cfg_i[p*FIELD_W +: FIELD_W];

        // R10: a set bit stays set unless a 1 is written to it
        a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (stat_i[p] && !clr_mask[p]) |=> stat_i[p]);

        // R3: synchronised rising edge in rising mode sets the bit
        a_r3_rise_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (fld == 4'd0 && cur_i[p] && !prev_i[p] && !clr_mask[p]) |=> stat_i[p]);

        // R5: high level in high mode sets the bit
        a_r5_high_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (fld == 4'd2 && cur_i[p] && !clr_mask[p]) |=> stat_i[p]);

        // R8: undefined codes never set a clear bit
        a_r8_bad_code_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (fld >= 4'd5 && !stat_i[p]) |=> !stat_i[p]);
    end

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
    .NUM_PINS (NUM_PINS),
    .FIELD_W  (FIELD_W),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
) i_gpio_irq_ctrl_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .irq_i   (irq_o),
    .cfg_i   (cfg_w),
    .en_i    (en_w),
    .stat_i  (stat_w),
    .cur_i   (cur_w),
    .prev_i  (prev_w)
);

// File: tb/test_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module test_gpio_irq_ctrl;

    localparam logic [4:0] A_CFG0 = 5'h00;
    localparam logic [4:0] A_CFG1 = 5'h04;
    localparam logic [4:0] A_CFG2 = 5'h08;
    localparam logic [4:0] A_CFG3 = 5'h0C;
    localparam logic [4:0] A_EN   = 5'h10;
    localparam logic [4:0] A_STAT = 5'h14;
    localparam logic [4:0] A_DEB  = 5'h18;
    localparam logic [4:0] A_HOLE = 5'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    gpio_irq_ctrl i_gpio_irq_ctrl (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .pin_i   (pins),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // All bus tasks start and end at a falling edge.
    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic cleanup();
        for (int k = 0; k < 4; k++) bus_write(5'(k * 4), 32'h0);
        pins = '0;
        settle();
        bus_write(A_EN, 32'h0);
        bus_write(A_STAT, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int k = 0; k < 8; k++) begin
            bus_read(5'(k * 4), v);
            check("R1 reset register", v, 32'h0);
        end
        check("R1 reset irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        bus_write(A_CFG0, 32'h1234_5678);
        bus_write(A_CFG1, 32'h9ABC_DEF0);
        bus_write(A_CFG2, 32'h0F1E_2D3C);
        bus_write(A_CFG3, 32'hA5A5_5A5A);
        bus_write(A_EN,   32'h0000_0000);
        bus_write(A_DEB,  32'hCAFE_0123);
        bus_read(A_CFG0, v); check("R2 cfg word0", v, 32'h1234_5678);
        bus_read(A_CFG1, v); check("R2 cfg word1", v, 32'h9ABC_DEF0);
        bus_read(A_CFG2, v); check("R2 cfg word2", v, 32'h0F1E_2D3C);
        bus_read(A_CFG3, v); check("R2 cfg word3", v, 32'hA5A5_5A5A);
        bus_read(A_DEB, v);  check("R2 debounce", v, 32'hCAFE_0123);
        bus_write(A_EN, 32'h8000_0001);
        bus_read(A_EN, v);   check("R2 enable", v, 32'h8000_0001);
        bus_write(A_HOLE, 32'hFFFF_FFFF);
        bus_read(A_HOLE, v); check("R12 hole reads 0", v, 32'h0);
        bus_read(A_DEB, v);  check("R12 hole write no effect deb", v, 32'hCAFE_0123);
        bus_read(A_EN, v);   check("R12 hole write no effect en", v, 32'h8000_0001);
        bus_write(A_DEB, 32'h0);
        cleanup();
    endtask

    task automatic t_rise();
        logic [31:0] v;
        pins[3] = 1'b1; settle();
        bus_read(A_STAT, v); check("R3 rise sets pin3", v, 32'h0000_0008);
        bus_write(A_STAT, 32'h0000_0008);
        pins[3] = 1'b0; settle();
        bus_read(A_STAT, v); check("R3 fall ignored", v, 32'h0);
        cleanup();
    endtask

    task automatic t_fall();
        logic [31:0] v;
        bus_write(A_CFG1, 32'h0000_0010);   // pin 9 -> code 1
        pins[9] = 1'b1; settle();
        bus_read(A_STAT, v); check("R4 rise ignored", v, 32'h0);
        pins[9] = 1'b0; settle();
        bus_read(A_STAT, v); check("R4 fall sets pin9", v, 32'h0000_0200);
        cleanup();
    endtask

    task automatic t_high();
        logic [31:0] v;
        bus_write(A_CFG2, 32'h0002_0000);   // pin 20 -> code 2
        pins[20] = 1'b1; settle();
        bus_read(A_STAT, v); check("R5 high sets pin20", v, 32'h0010_0000);
        bus_write(A_STAT, 32'h0010_0000);
        bus_read(A_STAT, v); check("R5 cleared for one cycle", v, 32'h0);
        bus_read(A_STAT, v); check("R5 set again while high", v, 32'h0010_0000);
        pins[20] = 1'b0; settle();
        bus_write(A_STAT, 32'h0010_0000);
        bus_read(A_STAT, v); check("R5 stays clear when low", v, 32'h0);
        cleanup();
    endtask

    task automatic t_low();
        logic [31:0] v;
        bus_write(A_CFG3, 32'h3000_0000);   // pin 31 -> code 3
        settle();
        bus_read(A_STAT, v); check("R6 low sets pin31", v, 32'h8000_0000);
        pins[31] = 1'b1; settle();
        bus_write(A_STAT, 32'h8000_0000);
        settle();
        bus_read(A_STAT, v); check("R6 high does not set", v, 32'h0);
        cleanup();
    endtask

    task automatic t_both();
        logic [31:0] v;
        bus_write(A_CFG1, 32'h0040_0000);   // pin 13 -> code 4
        pins[13] = 1'b1; settle();
        bus_read(A_STAT, v); check("R7 rise sets pin13", v, 32'h0000_2000);
        bus_write(A_STAT, 32'h0000_2000);
        pins[13] = 1'b0; settle();
        bus_read(A_STAT, v); check("R7 fall sets pin13", v, 32'h0000_2000);
        cleanup();
    endtask

    task automatic t_bad();
        logic [31:0] v;
        bus_write(A_CFG0, 32'h5070_0000);   // pin 5 -> 7, pin 7 -> 5
        bus_write(A_CFG1, 32'hF000_0000);   // pin 15 -> 15
        pins[5] = 1'b1; pins[7] = 1'b1; pins[15] = 1'b1; settle();
        pins[5] = 1'b0; pins[7] = 1'b0; pins[15] = 1'b0; settle();
        bus_read(A_STAT, v); check("R8 codes 5..15 never set", v, 32'h0);
        cleanup();
    endtask

    task automatic t_irq();
        logic [31:0] v;
        pins[3] = 1'b1; settle();
        bus_read(A_STAT, v); check("R9 status set while masked", v, 32'h0000_0008);
        check("R9 irq low while masked", {31'b0, irq}, 32'h0);
        bus_write(A_EN, 32'h0000_0010);
        check("R9 other enable keeps irq low", {31'b0, irq}, 32'h0);
        bus_write(A_EN, 32'h0000_0018);
        check("R9 irq high once enabled", {31'b0, irq}, 32'h1);
        bus_write(A_STAT, 32'h0000_0008);
        check("R9 irq low after clear", {31'b0, irq}, 32'h0);
        cleanup();
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        pins[3] = 1'b1; pins[13] = 1'b1; settle();
        bus_write(A_STAT, 32'h0);
        bus_read(A_STAT, v); check("R10 zero write keeps", v, 32'h0000_2008);
        bus_write(A_STAT, 32'h0000_0008);
        bus_read(A_STAT, v); check("R10 one clears only its bit", v, 32'h0000_2000);
        cleanup();
    endtask

    task automatic t_latency();
        bus_write(A_EN, 32'h0000_0040);
        pins[6] = 1'b1;
        @(negedge clk);
        check("R11 not after one edge", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R11 not after two edges", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R11 irq after three edges", {31'b0, irq}, 32'h1);
        cleanup();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_rise();
        t_fall();
        t_high();
        t_low();
        t_both();
        t_bad();
        t_irq();
        t_w1c();
        t_latency();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule